// File: doc/BRIEF.md
# Low-Power Mode Wake Controller

This block keeps track of which operating mode a microcontroller core is in and drives the controls that each mode implies. It knows five modes: two active modes (full speed and reduced speed), a subactive mode that runs the CPU from the low-speed clock, and two low-power modes. The deep low-power mode (standby) stops the system oscillator, gates the CPU clock and floats the I/O ports. The light low-power mode (watch) stops the oscillator and the CPU but leaves the ports holding their last state.

Software enters a low-power mode by pulsing a sleep request and naming the target. The controller leaves a low-power mode only on an interrupt that is enabled at its own source while the global interrupt mask is clear. When the mode it returns to needs the system oscillator, the controller turns the oscillator on and counts a settling window before it changes mode and pulses the exception-start output. The window length comes from a 3-bit select. A return from watch to subactive does not need the oscillator, so it skips the window. A reset, asserted asynchronously, forces full-speed active mode at once, and a reset-exception pulse follows the release of reset.

All logic runs on the always-running low-speed clock.

Top module: `lpw_wake_ctrl`

## Requirements
- R1: While reset is low, mode is 0 (active full speed), osc_en=1, cpu_clk_en=1, port_hiz=0, exc_start=0 and exc_reset=0. exc_reset is 1 for exactly one cycle after the first clock edge that follows the release of reset.
- R2: In an active or subactive mode, sleep_req=1 with sleep_tgt=0 makes mode 3 (standby) at the next edge. In standby, osc_en=0, cpu_clk_en=0 and port_hiz=1.
- R3: sleep_req=1 with sleep_tgt=1 makes mode 4 (watch) at the next edge. In watch, osc_en=0, cpu_clk_en=0 and port_hiz=0.
- R4: A low-power mode is left only when irq_mask=0 and irq_req[i]&irq_en[i]=1 for at least one source i. Otherwise mode and osc_en stay unchanged.
- R5: A wake that needs the oscillator sets osc_en=1 from the edge that samples it. The mode then stays the low-power mode for N=8<<settle_sel cycles (8 to 1024). At edge N after the wake, mode becomes the exit mode and exc_start=1.
- R6: Leaving standby goes to mode 1 (active reduced speed) when medspd_sel=1 and to mode 0 otherwise. lowspd_sel has no effect.
- R7: Leaving watch with lowspd_sel=1 goes to mode 2 (subactive) at the next edge, with exc_start=1 in that cycle and osc_en kept at 0. With lowspd_sel=0 it follows medspd_sel as in R6, after the R5 window.
- R8: In subactive mode, osc_en=0, cpu_clk_en=1 and port_hiz=0.
- R9: During a settling window, sleep_req and further interrupt requests are ignored, and the window length is unchanged. In a low-power mode, sleep_req has no effect.
- R10: Reset asserted in a low-power mode or during settling sets mode 0 and osc_en=1 without waiting for a clock edge.
- R11: exc_start is never 1 in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_lo | input | 1 | Always-running low-speed clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sleep_req | input | 1 | Request to enter a low-power mode |
| sleep_tgt | input | 1 | Target low-power mode: 0 standby, 1 watch |
| irq_req | input | NIRQ | Interrupt request lines |
| irq_en | input | NIRQ | Per-source interrupt enables |
| irq_mask | input | 1 | Global interrupt mask (1 blocks all wakes) |
| settle_sel | input | 3 | Settling window select, N = 8<<settle_sel |
| lowspd_sel | input | 1 | Watch exit goes to subactive when 1 |
| medspd_sel | input | 1 | Active exit uses reduced speed when 1 |
| mode | output | 3 | Current mode: 0 full, 1 reduced, 2 subactive, 3 standby, 4 watch |
| osc_en | output | 1 | System oscillator enable |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| port_hiz | output | 1 | I/O ports to high impedance |
| exc_start | output | 1 | One-cycle pulse that starts interrupt exception handling |
| exc_reset | output | 1 | One-cycle pulse that starts reset exception handling |

## Verification
The bench counts every cycle of the settling window at the smallest and at a larger select. A design off by one cycle would change mode or pulse exc_start a cycle early or late. It holds a wake request with only the global mask set, and then with only the source enable cleared. A design that ignores either gate would leave standby. It sets lowspd_sel while leaving standby, where a design that honours it would enter subactive, and it sends sleep and interrupt requests in the middle of a window, which a careless design would use to restart or abort the count. It also drops reset inside a window and checks that the reset-exception pulse appears only after release.

// File: rtl/lpw_pkg.sv
package lpw_pkg;

   typedef enum logic [2:0] {
      M_ACT_FULL = 3'd0,
      M_ACT_RED  = 3'd1,
      M_SUBACT   = 3'd2,
      M_STANDBY  = 3'd3,
      M_WATCH    = 3'd4
   } lpw_mode_e;

   function automatic logic lpw_is_sleep(input lpw_mode_e m);
      return (m == M_STANDBY) || (m == M_WATCH);
   endfunction

   function automatic logic lpw_needs_osc(input lpw_mode_e m);
      return (m == M_ACT_FULL) || (m == M_ACT_RED);
   endfunction

endpackage

// File: rtl/lpw_wake_qual.sv
module lpw_wake_qual #(
   parameter int NIRQ = 4
) (
   input  logic [NIRQ-1:0] irq_req,
   input  logic [NIRQ-1:0] irq_en,
   input  logic            irq_mask,
   output logic            wake
);

   if (NIRQ < 1) begin : g_bad_nirq
      $error("lpw_wake_qual: NIRQ must be at least 1");
   end

   logic [NIRQ-1:0] live;

   for (genvar i = 0; i < NIRQ; i++) begin : g_src
      assign live[i] = irq_req[i] & irq_en[i];
   end

   assign wake = ~irq_mask & (|live);

endmodule

// File: rtl/lpw_settle_timer.sv
module lpw_settle_timer #(
   parameter int SEL_W     = 3,
   parameter int BASE_LOG2 = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [SEL_W-1:0] sel,
   output logic             busy,
   output logic             expire
);

   localparam int MAX_LOG2 = BASE_LOG2 + (1 << SEL_W) - 1;
   localparam int CNT_W    = (MAX_LOG2 < 1) ? 1 : MAX_LOG2;
   localparam int SH_W     = $clog2(MAX_LOG2 + 2);

   if (SEL_W < 1 || SEL_W > 4) begin : g_bad_sel
      $error("lpw_settle_timer: SEL_W out of range 1..4");
   end
   if (BASE_LOG2 < 0 || MAX_LOG2 > 24) begin : g_bad_base
      $error("lpw_settle_timer: window exceeds 2**24 cycles");
   end

   logic [CNT_W-1:0] cnt_q;
   logic [SH_W-1:0]  shamt;
   logic [CNT_W:0]   full_len;
   logic [CNT_W:0]   load_val;

   assign shamt    = SH_W'(BASE_LOG2) + SH_W'(sel);
   assign full_len = (CNT_W+1)'(1) << shamt;
   assign load_val = full_len - (CNT_W+1)'(1);
   assign expire   = busy && (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         cnt_q <= '0;
      end else if (start) begin
         busy  <= 1'b1;
         cnt_q <= load_val[CNT_W-1:0];
      end else if (busy) begin
         if (cnt_q == '0) begin
            busy <= 1'b0;
         end else begin
            cnt_q <= cnt_q - 1'b1;
         end
      end
   end

endmodule

// File: rtl/lpw_out_dec.sv
module lpw_out_dec
   import lpw_pkg::*;
(
   input  lpw_mode_e mode,
   input  logic      settling,
   output logic      osc_en,
   output logic      cpu_clk_en,
   output logic      port_hiz
);

   always_comb begin
      osc_en     = lpw_needs_osc(mode) | settling;
      cpu_clk_en = ~lpw_is_sleep(mode);
      port_hiz   = (mode == M_STANDBY);
   end

endmodule

// File: rtl/lpw_wake_ctrl.sv
module lpw_wake_ctrl
   import lpw_pkg::*;
#(
   parameter int NIRQ      = 4,
   parameter int SEL_W     = 3,
   parameter int BASE_LOG2 = 3
) (
   input  logic             clk_lo,
   input  logic             rst_n,
   input  logic             sleep_req,
   input  logic             sleep_tgt,
   input  logic [NIRQ-1:0]  irq_req,
   input  logic [NIRQ-1:0]  irq_en,
   input  logic             irq_mask,
   input  logic [SEL_W-1:0] settle_sel,
   input  logic             lowspd_sel,
   input  logic             medspd_sel,
   output logic [2:0]       mode,
   output logic             osc_en,
   output logic             cpu_clk_en,
   output logic             port_hiz,
   output logic             exc_start,
   output logic             exc_reset
);

   lpw_mode_e mode_q;
   lpw_mode_e tgt_q;
   lpw_mode_e exit_tgt;
   logic      wake;
   logic      asleep;
   logic      settling;
   logic      expire;
   logic      start_settle;
   logic      exc_q;
   logic      rst_pend_q;
   logic      exc_rst_q;

   lpw_wake_qual #(.NIRQ(NIRQ)) u_qual (
      .irq_req  (irq_req),
      .irq_en   (irq_en),
      .irq_mask (irq_mask),
      .wake     (wake)
   );

   lpw_settle_timer #(.SEL_W(SEL_W), .BASE_LOG2(BASE_LOG2)) u_timer (
      .clk    (clk_lo),
      .rst_n  (rst_n),
      .start  (start_settle),
      .sel    (settle_sel),
      .busy   (settling),
      .expire (expire)
   );

   lpw_out_dec u_dec (
      .mode       (mode_q),
      .settling   (settling),
      .osc_en     (osc_en),
      .cpu_clk_en (cpu_clk_en),
      .port_hiz   (port_hiz)
   );

   assign asleep = lpw_is_sleep(mode_q);

   always_comb begin
      if (mode_q == M_WATCH && lowspd_sel) begin
         exit_tgt = M_SUBACT;
      end else if (medspd_sel) begin
         exit_tgt = M_ACT_RED;
      end else begin
         exit_tgt = M_ACT_FULL;
      end
   end

   assign start_settle = asleep && !settling && wake && (exit_tgt != M_SUBACT);

   always_ff @(posedge clk_lo or negedge rst_n) begin
      if (!rst_n) begin
         mode_q     <= M_ACT_FULL;
         tgt_q      <= M_ACT_FULL;
         exc_q      <= 1'b0;
         rst_pend_q <= 1'b1;
         exc_rst_q  <= 1'b0;
      end else begin
         exc_q      <= 1'b0;
         exc_rst_q  <= rst_pend_q;
         rst_pend_q <= 1'b0;
         if (!asleep) begin
            if (sleep_req) begin
               mode_q <= sleep_tgt ? M_WATCH : M_STANDBY;
            end
         end else if (settling) begin
            if (expire) begin
               mode_q <= tgt_q;
               exc_q  <= 1'b1;
            end
         end else if (wake) begin
            if (exit_tgt == M_SUBACT) begin
               mode_q <= M_SUBACT;
               exc_q  <= 1'b1;
            end else begin
               tgt_q <= exit_tgt;
            end
         end
      end
   end

   assign mode      = mode_q;
   assign exc_start = exc_q;
   assign exc_reset = exc_rst_q;

endmodule

// File: rtl/lpw_wake_chk.sv
module lpw_wake_chk #(
   parameter int NIRQ = 4
) (
   input logic            clk_lo,
   input logic            rst_n,
   input logic            sleep_req,
   input logic [NIRQ-1:0] irq_req,
   input logic [NIRQ-1:0] irq_en,
   input logic            irq_mask,
   input logic [2:0]      mode,
   input logic            osc_en,
   input logic            cpu_clk_en,
   input logic            port_hiz,
   input logic            exc_start
);

   logic lp;
   logic gate_open;
   assign lp        = (mode == 3'd3) || (mode == 3'd4);
   assign gate_open = !irq_mask && (|(irq_req & irq_en));

   p_hiz_standby_r2: assert property (@(posedge clk_lo) disable iff (!rst_n)
      port_hiz |-> (mode == 3'd3));

   p_cpu_gated_r3: assert property (@(posedge clk_lo) disable iff (!rst_n)
      lp |-> !cpu_clk_en);

   p_blocked_wake_r4: assert property (@(posedge clk_lo) disable iff (!rst_n)
      (lp && !osc_en && !gate_open) |=> ($stable(mode) && !osc_en));

   p_exit_pulse_r5: assert property (@(posedge clk_lo) disable iff (!rst_n)
      ($past(lp) && !lp) |-> exc_start);

   p_subact_clocks_r8: assert property (@(posedge clk_lo) disable iff (!rst_n)
      (mode == 3'd2) |-> (!osc_en && cpu_clk_en && !port_hiz));

   p_sleep_ignored_r9: assert property (@(posedge clk_lo) disable iff (!rst_n)
      (lp && sleep_req && !gate_open && !osc_en) |=> lp);

   p_one_cycle_exc_r11: assert property (@(posedge clk_lo) disable iff (!rst_n)
      exc_start |=> !exc_start);

endmodule

bind lpw_wake_ctrl lpw_wake_chk #(.NIRQ(NIRQ)) u_chk (
   .clk_lo     (clk_lo),
   .rst_n      (rst_n),
   .sleep_req  (sleep_req),
   .irq_req    (irq_req),
   .irq_en     (irq_en),
   .irq_mask   (irq_mask),
   .mode       (mode),
   .osc_en     (osc_en),
   .cpu_clk_en (cpu_clk_en),
   .port_hiz   (port_hiz),
   .exc_start  (exc_start)
);

// File: tb/tb_lpw_wake_ctrl.sv
`timescale 1ns/1ps
module tb_lpw_wake_ctrl;

   localparam int NIRQ = 4;

   logic            clk_lo = 1'b0;
   logic            rst_n;
   logic            sleep_req, sleep_tgt, irq_mask, lowspd_sel, medspd_sel;
   logic [NIRQ-1:0] irq_req, irq_en;
   logic [2:0]      settle_sel;
   logic [2:0]      mode;
   logic            osc_en, cpu_clk_en, port_hiz, exc_start, exc_reset;

   int n_tests = 0;
   int n_fail  = 0;

   always #2 clk_lo = ~clk_lo;

   lpw_wake_ctrl #(.NIRQ(NIRQ)) dut (
      .clk_lo(clk_lo), .rst_n(rst_n), .sleep_req(sleep_req), .sleep_tgt(sleep_tgt),
      .irq_req(irq_req), .irq_en(irq_en), .irq_mask(irq_mask), .settle_sel(settle_sel),
      .lowspd_sel(lowspd_sel), .medspd_sel(medspd_sel), .mode(mode), .osc_en(osc_en),
      .cpu_clk_en(cpu_clk_en), .port_hiz(port_hiz), .exc_start(exc_start),
      .exc_reset(exc_reset)
   );

   task automatic check(input string req, input string what, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk_lo);
   endtask

   task automatic outs(input string req, input int m, input int o, input int c, input int h);
      check(req, "mode", int'(mode), m);
      check(req, "osc_en", int'(osc_en), o);
      check(req, "cpu_clk_en", int'(cpu_clk_en), c);
      check(req, "port_hiz", int'(port_hiz), h);
   endtask

   task automatic go_sleep(input logic tgt);
      sleep_tgt = tgt;
      sleep_req = 1'b1;
      step();
      sleep_req = 1'b0;
   endtask

   // counts the window after the wake edge; lp is the sleep mode, tgt the exit mode
   task automatic ride_window(input string req, input int lp, input int n, input int tgt);
      for (int j = 1; j < n; j++) begin
         step();
         check(req, "mode in window", int'(mode), lp);
         check(req, "osc_en in window", int'(osc_en), 1);
         check(req, "exc_start in window", int'(exc_start), 0);
      end
      step();
      check(req, "exit mode", int'(mode), tgt);
      check(req, "exc_start at exit", int'(exc_start), 1);
      step();
      check("R11", "exc_start after pulse", int'(exc_start), 0);
   endtask

   task automatic t_reset();
      rst_n = 1'b0; sleep_req = 0; sleep_tgt = 0; irq_req = '0; irq_en = '0;
      irq_mask = 1'b1; settle_sel = 3'd0; lowspd_sel = 0; medspd_sel = 0;
      #9;
      outs("R1", 0, 1, 1, 0);
      check("R1", "exc_start in reset", int'(exc_start), 0);
      check("R1", "exc_reset in reset", int'(exc_reset), 0);
      step();
      rst_n = 1'b1;
      step();
      check("R1", "exc_reset after release", int'(exc_reset), 1);
      step();
      check("R1", "exc_reset second cycle", int'(exc_reset), 0);
   endtask

   task automatic t_standby_gates();
      go_sleep(1'b0);
      outs("R2", 3, 0, 0, 1);
      irq_req = 4'b0001; irq_en = 4'b0001; irq_mask = 1'b1;
      for (int k = 0; k < 4; k++) begin
         step();
         outs("R4 masked", 3, 0, 0, 1);
      end
      irq_mask = 1'b0; irq_en = 4'b1110;
      for (int k = 0; k < 4; k++) begin
         step();
         outs("R4 disabled", 3, 0, 0, 1);
      end
      sleep_req = 1'b1; sleep_tgt = 1'b1;
      step();
      sleep_req = 1'b0;
      check("R9", "sleep in standby ignored", int'(mode), 3);
      // wake via source 0 at smallest window, lowspd set must be ignored
      settle_sel = 3'd0; lowspd_sel = 1'b1; medspd_sel = 1'b0; irq_en = 4'b0001;
      step();
      irq_req = '0;
      outs("R5 wake edge", 3, 1, 0, 1);
      ride_window("R5 R6", 3, 8, 0);
      outs("R6", 0, 1, 1, 0);
      lowspd_sel = 1'b0;
   endtask

   task automatic t_standby_med_long();
      go_sleep(1'b0);
      settle_sel = 3'd3; medspd_sel = 1'b1;
      irq_req = 4'b0100; irq_en = 4'b0100; irq_mask = 1'b0;
      step();
      irq_req = '0;
      // mid-window: sleep and further interrupts must not disturb the count
      for (int j = 1; j < 64; j++) begin
         if (j == 10) begin sleep_req = 1'b1; irq_req = 4'b0100; end
         if (j == 12) begin sleep_req = 1'b0; irq_req = '0; end
         step();
         check("R9 R5", "mode in 64-cycle window", int'(mode), 3);
         check("R9 R5", "osc_en in 64-cycle window", int'(osc_en), 1);
      end
      step();
      check("R6", "reduced-speed exit", int'(mode), 1);
      check("R5", "exc_start at exit", int'(exc_start), 1);
      step();
      check("R11", "exc_start one cycle", int'(exc_start), 0);
      medspd_sel = 1'b0;
   endtask

   task automatic t_watch_subact();
      go_sleep(1'b1);
      outs("R3", 4, 0, 0, 0);
      lowspd_sel = 1'b1;
      irq_req = 4'b1000; irq_en = 4'b1000; irq_mask = 1'b0;
      step();
      irq_req = '0;
      check("R7", "subactive at once", int'(mode), 2);
      check("R7", "exc_start at once", int'(exc_start), 1);
      outs("R8", 2, 0, 1, 0);
      step();
      check("R11", "exc_start one cycle", int'(exc_start), 0);
      lowspd_sel = 1'b0;
   endtask

   task automatic t_watch_active();
      go_sleep(1'b1);
      outs("R3", 4, 0, 0, 0);
      settle_sel = 3'd1; medspd_sel = 1'b1;
      irq_req = 4'b0010; irq_en = 4'b0010; irq_mask = 1'b0;
      step();
      irq_req = '0;
      outs("R7 wake edge", 4, 1, 0, 0);
      ride_window("R7", 4, 16, 1);
      medspd_sel = 1'b0;
   endtask

   task automatic t_reset_in_window();
      go_sleep(1'b0);
      settle_sel = 3'd2;
      irq_req = 4'b0001; irq_en = 4'b0001; irq_mask = 1'b0;
      step();
      irq_req = '0;
      step(); step();
      #1 rst_n = 1'b0;
      #0.5;
      outs("R10", 0, 1, 1, 0);
      check("R10", "exc_reset held low", int'(exc_reset), 0);
      step();
      rst_n = 1'b1;
      step();
      check("R10", "exc_reset after release", int'(exc_reset), 1);
      outs("R10", 0, 1, 1, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk_lo);
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      t_reset();
      t_standby_gates();
      t_standby_med_long();
      t_watch_subact();
      t_watch_active();
      t_reset_in_window();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule